// File: doc/BRIEF.md
# Adaptive Word-Length and Sample-Rate Controller

This block sets the numeric precision and the sample rate of a receiver datapath once per packet. While the preamble and start-of-frame delimiter are being acquired, it keeps the datapath at full precision (8-bit words) and at the full rate (an enable on every clock). When synchronization succeeds, it reads a constant lookup table. The table is indexed by the detected interference class and by a quantized SNR bin. It returns the cheapest word length and sample rate that still meet the error target. These settings stay in force for the data portion of the packet. At end of packet, or when synchronization is lost, the block goes back to full settings.

The rate is produced as a clock-enable strobe at an integer fraction of the maximum rate. The permitted rates are 30, 15, 10, 6, 5, 3, 2 and 1 Msps. A rate requested by the table that is not in this set is rounded up to the next permitted rate. The incoming multi-bit sample is requantized by an arithmetic right shift. The shift keeps the sign, so only the low-order bits toggle. Each change of settings clears the datapath output register and restarts the rate divider.

Top module: `wlr_ctrl`

## Requirements
- R1: After reset, and at every point outside the data phase, `width_code` is 3 (8 bits) and `rate_code` is 0 (divide by 1), so `sample_en` is high on every cycle except the flush cycle.
- R2: A `sync_found` pulse during acquisition makes `data_phase` go high in the next cycle. In that same cycle `flush` is high for one cycle and the settings come from the table entry addressed by the `intf_class` and `snr_bin` values present with the pulse.
- R3: Each table entry holds a width code (0=1, 1=2, 2=4, 3=8 bits) and a requested rate. Among the entries: class 0 bin 1 gives width code 1 at 7 Msps; class 2 bin 4 gives width code 2 at 6 Msps; class 0 bin 5 gives width code 0 at 1 Msps; class 1 bin 4 gives width code 3 at 5 Msps. Classes are: 0 noise only, 1 adjacent-channel only, 2 alternate-channel only, 3 both.
- R4: A requested rate is rounded up to the nearest permitted rate. The codes map as 0:30, 1:15, 2:10, 3:6, 4:5, 5:3, 6:2 and 7:1 Msps, which are divisors of 1, 2, 3, 5, 6, 10, 15 and 30.
- R5: `sample_en` is high for one cycle out of every divisor cycles. After a settings switch, the first enable comes exactly one divisor count of cycles after the flush cycle begins.
- R6: On each enable, `sample_out` holds the input sample captured at that edge, arithmetically shifted right by 8 minus the selected width.
- R7: During the flush cycle, `sample_en` is low and `sample_out` is zero.
- R8: A `pkt_end` or `sync_lost` pulse during the data phase returns the block to full settings, with `data_phase` low and a one-cycle `flush`.
- R9: A `sync_found` pulse during the data phase, and `pkt_end` or `sync_lost` during acquisition, cause no flush and no change of settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the maximum sample rate |
| rst_n | input | 1 | Synchronous reset, active low |
| intf_class | input | 2 | Detected interference class |
| snr_bin | input | BIN_W | Quantized SNR level |
| sync_found | input | 1 | One-cycle pulse: synchronization achieved |
| pkt_end | input | 1 | One-cycle pulse: end of packet |
| sync_lost | input | 1 | One-cycle pulse: synchronization lost |
| sample_in | input | IN_W | Signed full-precision sample |
| sample_en | output | 1 | Datapath sample enable strobe |
| sample_out | output | IN_W | Requantized signed sample |
| width_code | output | 2 | Active word-length code |
| rate_code | output | 3 | Active sample-rate code |
| data_phase | output | 1 | High while economical settings apply |
| flush | output | 1 | One-cycle pulse: datapath contents discarded |

## Verification
The bench enters the data phase with four table entries. Together they cover all four word lengths and divisors of 3, 5, 6 and 30. One entry requests a rate that must be rounded up, and the others request rates already in the permitted set, which tells rounding apart from exact matches. Each phase sends a negative and a positive sample. The shifted results expose sign loss or a wrong shift amount, and the measured gaps between enables expose divisor and restart errors. Out-of-phase pulses and both exit causes are applied to separate the ignored cases from the real transitions.

// File: rtl/wlr_pkg.sv
// Shared constants and functions for the word-length and rate controller.
// Assumes 4 interference classes and a power-of-two number of SNR bins.
package wlr_pkg;

    localparam int unsigned MAX_DIV  = 30;
    localparam int unsigned CNT_W    = $clog2(MAX_DIV + 1);
    localparam logic [1:0]  FULL_WC  = 2'd3;
    localparam logic [2:0]  FULL_RC  = 3'd0;

    // One table entry: width code and requested rate in Msps
    typedef struct packed {
        logic [1:0] wcode;
        logic [4:0] req_msps;
    } lut_entry_t;

    // Constant table contents; bins beyond the eighth use the cheapest setting
    function automatic lut_entry_t lut_entry(input int unsigned cls, input int unsigned bin);
        lut_entry_t e;
        e = '{wcode: 2'd0, req_msps: 5'd1};
        case (cls)
            0: case (bin)
                0: e = '{2'd1, 5'd13};
                1: e = '{2'd1, 5'd7};
                2: e = '{2'd1, 5'd4};
                default: e = '{2'd0, 5'd1};
            endcase
            1: case (bin)
                0: e = '{2'd3, 5'd12};
                1: e = '{2'd2, 5'd8};
                2: e = '{2'd2, 5'd8};
                3: e = '{2'd2, 5'd7};
                4: e = '{2'd3, 5'd5};
                default: e = '{2'd0, 5'd1};
            endcase
            2: case (bin)
                0: e = '{2'd2, 5'd13};
                1: e = '{2'd2, 5'd12};
                2: e = '{2'd2, 5'd4};
                3: e = '{2'd2, 5'd4};
                4: e = '{2'd2, 5'd6};
                default: e = '{2'd0, 5'd1};
            endcase
            default: case (bin)
                0: e = '{2'd3, 5'd14};
                1: e = '{2'd3, 5'd13};
                2: e = '{2'd3, 5'd7};
                3: e = '{2'd2, 5'd7};
                4: e = '{2'd2, 5'd6};
                5: e = '{2'd1, 5'd3};
                default: e = '{2'd0, 5'd1};
            endcase
        endcase
        return e;
    endfunction

    // Round a requested rate up to the nearest permitted rate code
    function automatic logic [2:0] round_up_rate(input logic [4:0] msps);
        if      (msps <= 5'd1)  return 3'd7;
        else if (msps <= 5'd2)  return 3'd6;
        else if (msps <= 5'd3)  return 3'd5;
        else if (msps <= 5'd5)  return 3'd4;
        else if (msps <= 5'd6)  return 3'd3;
        else if (msps <= 5'd10) return 3'd2;
        else if (msps <= 5'd15) return 3'd1;
        else                    return 3'd0;
    endfunction

    // Clock divisor for a rate code
    function automatic logic [CNT_W-1:0] rate_div(input logic [2:0] code);
        case (code)
            3'd0:    return CNT_W'(1);
            3'd1:    return CNT_W'(2);
            3'd2:    return CNT_W'(3);
            3'd3:    return CNT_W'(5);
            3'd4:    return CNT_W'(6);
            3'd5:    return CNT_W'(10);
            3'd6:    return CNT_W'(15);
            default: return CNT_W'(MAX_DIV);
        endcase
    endfunction

endpackage

// File: rtl/wlr_lut.sv
// Settings lookup: constant table of 4 classes x N_BINS bins, followed by
// rate round-up. Purely combinational. Assumes N_BINS is a power of two.
module wlr_lut #(
    parameter int unsigned N_BINS = 8,
    localparam int unsigned BIN_W = $clog2(N_BINS),
    localparam int unsigned DEPTH = 4 * N_BINS
) (
    input  logic [1:0]       cls,
    input  logic [BIN_W-1:0] bin,
    output logic [1:0]       wcode,
    output logic [2:0]       rcode
);
    import wlr_pkg::*;

    lut_entry_t rom [DEPTH];
    lut_entry_t sel;

    // Fill the constant table one entry per class and bin
    for (genvar c = 0; c < 4; c++) begin : g_cls
        for (genvar b = 0; b < N_BINS; b++) begin : g_bin
            assign rom[c*N_BINS + b] = lut_entry(c, b);
        end
    end

    // Read the addressed entry and quantize its rate upward
    always_comb begin
        sel   = rom[{cls, bin}];
        wcode = sel.wcode;
        rcode = round_up_rate(sel.req_msps);
    end
endmodule

// File: rtl/wlr_rate_gen.sv
// Divide-by-N enable generator. The divisor comes from the rate code.
// A restart clears the count, so the next tick comes a full period later.
module wlr_rate_gen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [2:0] rcode,
    output logic       wrap,
    output logic       tick
);
    import wlr_pkg::*;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Terminal count for the active divisor, and wrap detection
    always_comb begin
        last = rate_div(rcode) - CNT_W'(1);
        wrap = !restart && (cnt >= last);
    end

    // Count cycles and register the enable strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (restart) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + CNT_W'(1);
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/wlr_requant.sv
// Sign-preserving requantizer: arithmetic shift right by IN_W minus the
// selected width, captured on each sample tick and cleared on flush.
// Assumes IN_W >= 8.
module wlr_requant #(
    parameter int unsigned IN_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            capture,
    input  logic [1:0]      wcode,
    input  logic [IN_W-1:0] din,
    output logic [IN_W-1:0] dout
);
    localparam int unsigned SH_W = $clog2(IN_W + 1);

    logic [SH_W-1:0] shamt;
    logic [IN_W-1:0] shifted;

    // Shift amount from width code and the shifted value
    always_comb begin
        shamt   = SH_W'(IN_W) - (SH_W'(1) << wcode);
        shifted = IN_W'($signed(din) >>> shamt);
    end

    // Hold the requantized sample, discard it on a settings switch
    always_ff @(posedge clk) begin
        if (!rst_n || clear) dout <= '0;
        else if (capture)    dout <= shifted;
    end
endmodule

// File: rtl/wlr_ctrl.sv
// Top: packet-phase control of word length and sample rate. Full settings
// during acquisition, table settings after sync until end or loss.
// Assumes the control pulses last one cycle.
module wlr_ctrl #(
    parameter int unsigned IN_W   = 8,
    parameter int unsigned N_BINS = 8,
    localparam int unsigned BIN_W = $clog2(N_BINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       intf_class,
    input  logic [BIN_W-1:0] snr_bin,
    input  logic             sync_found,
    input  logic             pkt_end,
    input  logic             sync_lost,
    input  logic [IN_W-1:0]  sample_in,
    output logic             sample_en,
    output logic [IN_W-1:0]  sample_out,
    output logic [1:0]       width_code,
    output logic [2:0]       rate_code,
    output logic             data_phase,
    output logic             flush
);
    import wlr_pkg::*;

    logic [1:0] lut_wc;
    logic [2:0] lut_rc;
    logic       go_data, go_full, switch_now, wrap;

    wlr_lut #(.N_BINS(N_BINS)) lut_i (
        .cls(intf_class), .bin(snr_bin), .wcode(lut_wc), .rcode(lut_rc)
    );

    // Phase transition decode; out-of-phase pulses are ignored
    always_comb begin
        go_data    = !data_phase && sync_found;
        go_full    = data_phase && (pkt_end || sync_lost);
        switch_now = go_data || go_full;
    end

    // Phase, settings and flush registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_phase <= 1'b0;
            width_code <= FULL_WC;
            rate_code  <= FULL_RC;
            flush      <= 1'b0;
        end else begin
            flush <= switch_now;
            if (go_data) begin
                data_phase <= 1'b1;
                width_code <= lut_wc;
                rate_code  <= lut_rc;
            end else if (go_full) begin
                data_phase <= 1'b0;
                width_code <= FULL_WC;
                rate_code  <= FULL_RC;
            end
        end
    end

    wlr_rate_gen rate_i (
        .clk(clk), .rst_n(rst_n), .restart(switch_now),
        .rcode(rate_code), .wrap(wrap), .tick(sample_en)
    );

    wlr_requant #(.IN_W(IN_W)) rq_i (
        .clk(clk), .rst_n(rst_n), .clear(switch_now), .capture(wrap),
        .wcode(width_code), .din(sample_in), .dout(sample_out)
    );
endmodule

// File: rtl/wlr_ctrl_chk.sv
// Property checker for wlr_ctrl, attached by bind.
module wlr_ctrl_chk #(
    parameter int unsigned IN_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            data_phase,
    input logic            flush,
    input logic            sample_en,
    input logic [IN_W-1:0] sample_out,
    input logic [1:0]      width_code,
    input logic [2:0]      rate_code
);
    // R1
    acq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_phase |-> (width_code == 2'd3 && rate_code == 3'd0));
    // R2
    enter_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_phase) |-> flush);
    // R5
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && rate_code != 3'd0) |=> !sample_en);
    // R7
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!sample_en && sample_out == '0));
    // R8
    exit_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_phase) |-> flush);
    // R9
    settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_phase && $past(data_phase)) |-> ($stable(width_code) && $stable(rate_code) && !flush));
endmodule

bind wlr_ctrl wlr_ctrl_chk #(.IN_W(IN_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .data_phase(data_phase), .flush(flush),
    .sample_en(sample_en), .sample_out(sample_out),
    .width_code(width_code), .rate_code(rate_code)
);

// File: tb/wlr_ctrl_tb_top.sv
module wlr_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] intf_class = '0;
    logic [2:0] snr_bin = '0;
    logic       sync_found = 1'b0, pkt_end = 1'b0, sync_lost = 1'b0;
    logic [7:0] sample_in = '0;
    logic       sample_en, data_phase, flush;
    logic [7:0] sample_out;
    logic [1:0] width_code;
    logic [2:0] rate_code;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] exp_q[$];
    string      req_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wlr_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .intf_class(intf_class), .snr_bin(snr_bin),
        .sync_found(sync_found), .pkt_end(pkt_end), .sync_lost(sync_lost),
        .sample_in(sample_in), .sample_en(sample_en), .sample_out(sample_out),
        .width_code(width_code), .rate_code(rate_code),
        .data_phase(data_phase), .flush(flush)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pop one expected sample per enable
    always @(negedge clk) begin
        if (sample_en && exp_q.size() > 0) begin
            logic [7:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(sample_out == e, r, sample_out, e);
        end
    end

    // Driver: present a sample and queue its expected requantized value (R6)
    task automatic send(input logic [7:0] x, input int wbits);
        @(negedge clk); #1;
        sample_in = x;
        exp_q.push_back(8'($signed(x) >>> (8 - wbits)));
        req_q.push_back("R6");
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    // One-cycle control pulse; returns inside the following cycle
    task automatic pulse(input int which, input logic [1:0] c, input logic [2:0] b);
        @(negedge clk); #1;
        intf_class = c; snr_bin = b;
        if (which == 0) sync_found = 1'b1;
        else if (which == 1) pkt_end = 1'b1;
        else sync_lost = 1'b1;
        @(negedge clk); #1;
        sync_found = 1'b0; pkt_end = 1'b0; sync_lost = 1'b0;
    endtask

    // Cycles from now (flush cycle) until the next enable
    task automatic gap_to_en(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!sample_en && n < 100);
    endtask

    task automatic enter_data(input logic [1:0] c, input logic [2:0] b,
                              input int ewc, input int erc, input int ediv, input string tag);
        int g;
        pulse(0, c, b);
        check(data_phase && flush, {tag, " R2 enter"}, {data_phase, flush}, 3);
        check(width_code == ewc, {tag, " R3 width"}, width_code, ewc);
        check(rate_code == erc, {tag, " R4 rate"}, rate_code, erc);
        check(!sample_en && sample_out == 0, {tag, " R7 flush"}, sample_out, 0);
        gap_to_en(g);
        check(g == ediv, {tag, " R5 first"}, g, ediv);
        gap_to_en(g);
        check(g == ediv, {tag, " R5 period"}, g, ediv);
    endtask

    task automatic leave_data(input int which);
        int g;
        pulse(which, 2'd0, 3'd0);
        check(!data_phase && flush, "R8 exit", {data_phase, flush}, 1);
        check(width_code == 3 && rate_code == 0, "R1 full", width_code, 3);
        gap_to_en(g);
        check(g == 1, "R1 every cycle", g, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++; n_checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!data_phase && !flush && width_code == 3 && rate_code == 0, "R1 reset", width_code, 3);
        cnt = 0;
        for (int i = 0; i < 10; i++) begin @(negedge clk); cnt += sample_en; end
        check(cnt == 10, "R1 rate", cnt, 10);
        send(8'hB6, 8); send(8'h5A, 8);
        // R9: exits while acquiring are ignored
        pulse(1, 0, 0);
        check(!flush && !data_phase, "R9 pkt_end ignored", flush, 0);
        pulse(2, 0, 0);
        check(!flush && !data_phase, "R9 sync_lost ignored", flush, 0);

        // R3/R4: 7 Msps rounds up to 10 (code 2, div 3), 2-bit
        enter_data(2'd0, 3'd1, 1, 2, 3, "c0b1");
        send(8'hB6, 2); send(8'h5A, 2);
        pulse(0, 2'd3, 3'd0);
        check(!flush && width_code == 1 && rate_code == 2, "R9 resync ignored", rate_code, 2);
        leave_data(1);
        send(8'hB6, 8);

        // 6 Msps exact (code 3, div 5), 4-bit; exit by sync loss
        enter_data(2'd2, 3'd4, 2, 3, 5, "c2b4");
        send(8'hB6, 4); send(8'h5A, 4);
        leave_data(2);

        // 1 Msps (code 7, div 30), 1-bit
        enter_data(2'd0, 3'd5, 0, 7, 30, "c0b5");
        send(8'hB6, 1); send(8'h5A, 1);
        leave_data(1);

        // 5 Msps (code 4, div 6), 8-bit
        enter_data(2'd1, 3'd4, 3, 4, 6, "c1b4");
        send(8'hB6, 8); send(8'h5A, 8);
        leave_data(2);

        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule